// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small multi-cycle processor. Its only working register is an 8-bit accumulator. Every instruction is one byte. The top three bits select one of eight operations, and the low five bits name a word in a 32-entry memory. The core reads the instruction at the program counter and keeps it in an instruction register. It then splits that register into a held opcode and a held operand address, and advances the program counter. After that it carries out the operation.

The memory is outside the core. It is synchronous and returns read data one cycle after the address is presented. For this reason every read phase has two states: one that issues the address and one that captures the data. Arithmetic and logic instructions and loads therefore take five cycles. Stores and jumps take four cycles, and so does the halt instruction that stops the core. The accumulator value and a sticky stopped flag are brought out so that a test environment can watch the program run.

Top module: `acc_cpu`

## Requirements
- R1: An instruction byte carries its opcode in bits 7:5 and a memory address in bits 4:0. The codes are: 000 add, 001 subtract, 010 nand, 011 nor, 100 load, 101 store, 110 jump, 111 halt.
- R2: While reset is high at a clock edge, the program counter, the accumulator and the stopped flag are cleared and no write is issued. After reset the first instruction is read from address 0.
- R3: Each instruction is fetched from the program counter, which advances by one per instruction. The add, subtract, nand, nor and load instructions take 5 cycles each. The store, jump and halt instructions take 4 cycles each.
- R4: Add (000) replaces the accumulator with the accumulator plus the addressed word, modulo 256. The accumulator changes only at the end of a data-capture cycle.
- R5: Subtract (001) replaces the accumulator with the accumulator minus the addressed word, modulo 256.
- R6: Nand (010) and nor (011) replace the accumulator with the bitwise NAND or NOR of the accumulator and the addressed word.
- R7: Load (100) copies the addressed word into the accumulator.
- R8: Store (101) writes the accumulator to the addressed word in a single write-enable cycle. The accumulator is left unchanged.
- R9: Jump (110) sets the program counter to the address field and leaves the accumulator unchanged. The skipped instructions have no effect.
- R10: Halt (111) raises the stopped flag, which stays high until reset. While the flag is high there are no memory writes, and the accumulator and program counter hold their values.
- R11: The program counter wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 5 | Memory address for the read or write |
| mem_wdata | output | 8 | Data to write (the accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| halted | output | 1 | Sticky stopped flag |
| acc_out | output | 8 | Current accumulator value |

## Verification
A wrong opcode split or address split shows up quickly. The first load or store after reset touches the wrong memory word, and the accumulator or the stored byte is wrong within about ten cycles. A program counter that increments wrongly or jumps to the wrong place changes which instructions run. This shows up as a wrong total cycle count before the stopped flag rises, or as a write to a word that should have been skipped. A faulty stop state shows up at once as accumulator movement or write strobes after the flag is high. The wrap case uses self-modifying code, so it only ends if the program counter really returns to 0.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // Operation codes held in the top three bits of an instruction.
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_NAND = 3'b010,
    OP_NOR  = 3'b011,
    OP_LOAD = 3'b100,
    OP_STOR = 3'b101,
    OP_JMP  = 3'b110,
    OP_HALT = 3'b111
  } op_e;

  localparam int OPC_W = 3;

  // Sequencer states; a memory read spends one state issuing the address
  // and the next capturing the returned data.
  typedef enum logic [2:0] {
    ST_FADDR  = 3'd0,
    ST_FDATA  = 3'd1,
    ST_DECODE = 3'd2,
    ST_XADDR  = 3'd3,
    ST_XDATA  = 3'd4,
    ST_STOP   = 3'd5
  } state_e;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  function automatic logic [W-1:0] alu_fn(op_e f, logic [W-1:0] x, logic [W-1:0] m);
    logic [W-1:0] r;
    case (f)
      OP_ADD:  r = x + m;
      OP_SUB:  r = x - m;
      OP_NAND: r = ~(x & m);
      OP_NOR:  r = ~(x | m);
      default: r = m;           // load passes the operand through
    endcase
    return r;
  endfunction

  always_comb y = alu_fn(op, a, b);

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  op_e    opr,
  output state_e state,
  output logic   ir_en,
  output logic   dec_en,
  output logic   acc_en,
  output logic   jmp_en,
  output logic   wr_en,
  output logic   use_addr,
  output logic   halted
);

  state_e state_q, state_d;
  logic   halt_set;
  logic   halted_q;

  always_comb begin
    state_d  = state_q;
    ir_en    = 1'b0;
    dec_en   = 1'b0;
    acc_en   = 1'b0;
    jmp_en   = 1'b0;
    wr_en    = 1'b0;
    halt_set = 1'b0;
    use_addr = 1'b0;
    case (state_q)
      ST_FADDR:  state_d = ST_FDATA;
      ST_FDATA: begin
        ir_en   = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        dec_en  = 1'b1;
        state_d = ST_XADDR;
      end
      ST_XADDR: begin
        use_addr = 1'b1;
        case (opr)
          OP_STOR: begin
            wr_en   = 1'b1;
            state_d = ST_FADDR;
          end
          OP_JMP: begin
            jmp_en  = 1'b1;
            state_d = ST_FADDR;
          end
          OP_HALT: begin
            halt_set = 1'b1;
            state_d  = ST_STOP;
          end
          default: state_d = ST_XDATA;
        endcase
      end
      ST_XDATA: begin
        use_addr = 1'b1;
        acc_en   = 1'b1;
        state_d  = ST_FADDR;
      end
      ST_STOP: begin
        use_addr = 1'b1;
        state_d  = ST_STOP;
      end
      default: state_d = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_FADDR;
      halted_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (halt_set) halted_q <= 1'b1;
    end
  end

  assign state  = state_q;
  assign halted = halted_q;

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ir_en,
  input  logic              dec_en,
  input  logic              acc_en,
  input  logic              jmp_en,
  input  logic              use_addr,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] alu_y,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] addr,
  output op_e               opr,
  output logic [DATA_W-1:0] acc
);

  logic [ADDR_W-1:0] pc_q, addr_q;
  logic [DATA_W-1:0] ir_q, acc_q;
  op_e               opr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ir_q   <= '0;
      opr_q  <= OP_ADD;
      addr_q <= '0;
      acc_q  <= '0;
    end else begin
      if (ir_en) ir_q <= rdata;
      if (dec_en) begin
        opr_q  <= op_e'(ir_q[DATA_W-1 -: OPC_W]);
        addr_q <= ir_q[ADDR_W-1:0];
        pc_q   <= pc_q + ADDR_W'(1);
      end else if (jmp_en) begin
        pc_q <= addr_q;
      end
      if (acc_en) acc_q <= alu_y;
    end
  end

  assign mem_addr = use_addr ? addr_q : pc_q;
  assign pc       = pc_q;
  assign addr     = addr_q;
  assign opr      = opr_q;
  assign acc      = acc_q;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted,
  output logic [DATA_W-1:0] acc_out
);

  // Named internal events, watched by the bound checker.
  state_e            state_q;
  op_e               opr_q;
  logic [ADDR_W-1:0] pc_q, addr_q;
  logic [DATA_W-1:0] acc_q, alu_y;
  logic              evt_fetch, evt_decode, evt_acc_wr, evt_jump, evt_store;
  logic              use_addr;

  acc_cpu_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opr      (opr_q),
    .state    (state_q),
    .ir_en    (evt_fetch),
    .dec_en   (evt_decode),
    .acc_en   (evt_acc_wr),
    .jmp_en   (evt_jump),
    .wr_en    (evt_store),
    .use_addr (use_addr),
    .halted   (halted)
  );

  acc_cpu_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ir_en    (evt_fetch),
    .dec_en   (evt_decode),
    .acc_en   (evt_acc_wr),
    .jmp_en   (evt_jump),
    .use_addr (use_addr),
    .rdata    (mem_rdata),
    .alu_y    (alu_y),
    .mem_addr (mem_addr),
    .pc       (pc_q),
    .addr     (addr_q),
    .opr      (opr_q),
    .acc      (acc_q)
  );

  acc_cpu_alu #(.W(DATA_W)) u_alu (
    .op (opr_q),
    .a  (acc_q),
    .b  (mem_rdata),
    .y  (alu_y)
  );

  assign mem_we    = evt_store;
  assign mem_wdata = acc_q;
  assign acc_out   = acc_q;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic              halted,
  input logic [DATA_W-1:0] acc_out,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] addr_q,
  input op_e               opr_q,
  input logic              evt_decode,
  input logic              evt_jump,
  input logic              evt_acc_wr
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (pc_q == '0 && acc_out == '0 && !halted && !mem_we)); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) evt_decode |=> pc_q == $past(pc_q) + ADDR_W'(1)); // R3
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst) !evt_acc_wr |=> $stable(acc_out)); // R4
  AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (rst) mem_we |-> opr_q == OP_STOR); // R8
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst) evt_jump |=> (pc_q == $past(addr_q) && $stable(acc_out))); // R9
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst) halted |=> (halted && $stable(acc_out) && $stable(pc_q) && !mem_we)); // R10

endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_we     (mem_we),
  .halted     (halted),
  .acc_out    (acc_out),
  .pc_q       (pc_q),
  .addr_q     (addr_q),
  .opr_q      (opr_q),
  .evt_decode (evt_decode),
  .evt_jump   (evt_jump),
  .evt_acc_wr (evt_acc_wr)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {opcode, accumulator start, operand, expected result}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0, 8'h05, 8'h06, 8'h0B},
    {8'd0, 8'hF0, 8'h20, 8'h10},
    {8'd1, 8'h03, 8'h05, 8'hFE},
    {8'd1, 8'h80, 8'h01, 8'h7F},
    {8'd2, 8'hF0, 8'h3C, 8'hCF},
    {8'd2, 8'hFF, 8'hFF, 8'h00},
    {8'd3, 8'hF0, 8'h0C, 8'h03},
    {8'd3, 8'h00, 8'h00, 8'hFF},
    {8'd4, 8'h12, 8'hA5, 8'hA5},
    {8'd4, 8'h77, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic       mem_we, halted;
  logic [7:0] acc_out;

  logic [7:0] mem [32];
  logic       tb_we = 1'b0;
  logic [4:0] tb_addr = '0;
  logic [7:0] tb_data = '0;
  int         we_cnt = 0;
  int         cyc_total = 0;
  int         n_tests = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .acc_out(acc_out)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (mem_we) we_cnt <= we_cnt + 1;
    cyc_total <= cyc_total + 1;
    if (cyc_total > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc_total);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    tb_addr = a; tb_data = d; tb_we = 1'b1;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) poke(5'(i), 8'h00);
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk); #1;
      cyc++;
    end
  endtask

  function automatic string tag_of(logic [7:0] op);
    case (op)
      8'd0: return "R4 add";
      8'd1: return "R5 sub";
      8'd2: return "R6 nand";
      8'd3: return "R6 nor";
      default: return "R7 load";
    endcase
  endfunction

  initial begin
    int cyc;
    int we0;
    logic [7:0] acc_hold;
    // R2: reset state
    repeat (3) @(negedge clk);
    check("R2 halted at reset", halted, 0);
    check("R2 acc at reset", acc_out, 0);
    check("R2 no write at reset", mem_we, 0);
    check("R2 first fetch address", mem_addr, 0);

    // R1 opcode field decode through the table
    for (int v = 0; v < NVEC; v++) begin
      rst = 1'b1;
      clear_mem();
      poke(5'd0, {3'b100, 5'd16});
      poke(5'd1, {VEC[v][26:24], 5'd17});
      poke(5'd2, {3'b101, 5'd18});
      poke(5'd3, 8'hE0);
      poke(5'd16, VEC[v][23:16]);
      poke(5'd17, VEC[v][15:8]);
      run(cyc);
      check({tag_of(VEC[v][31:24]), " R1 result"}, acc_out, VEC[v][7:0]);
      check("R8 stored result", mem[18], VEC[v][7:0]);
      if (v == 0) check("R3 cycles load-op-store-halt", cyc, 18);
    end

    // Sum of five words at 20..24 stored at 25
    rst = 1'b1;
    clear_mem();
    poke(5'd0, {3'b100, 5'd20});
    poke(5'd1, {3'b000, 5'd21});
    poke(5'd2, {3'b000, 5'd22});
    poke(5'd3, {3'b000, 5'd23});
    poke(5'd4, {3'b000, 5'd24});
    poke(5'd5, {3'b101, 5'd25});
    poke(5'd6, 8'hE0);
    poke(5'd20, 8'd10); poke(5'd21, 8'd20); poke(5'd22, 8'd30);
    poke(5'd23, 8'd40); poke(5'd24, 8'd50);
    we0 = we_cnt;
    run(cyc);
    check("R4 sum stored at 25", mem[25], 150);
    check("R4 sum in acc", acc_out, 150);
    check("R3 sum program cycles", cyc, 33);
    check("R8 single write strobe", we_cnt - we0, 1);

    // R10: frozen after halt
    acc_hold = acc_out;
    we0 = we_cnt;
    repeat (10) @(negedge clk);
    check("R10 halted sticky", halted, 1);
    check("R10 acc frozen", acc_out, acc_hold);
    check("R10 no writes while halted", we_cnt - we0, 0);
    check("R10 memory untouched", mem[25], 150);

    // R2: reset releases halt
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 halt cleared by reset", halted, 0);
    check("R2 acc cleared by reset", acc_out, 0);

    // R9: jump skips an instruction
    clear_mem();
    poke(5'd0, {3'b100, 5'd16});
    poke(5'd1, {3'b110, 5'd5});
    poke(5'd2, {3'b101, 5'd18});
    poke(5'd5, {3'b101, 5'd19});
    poke(5'd6, 8'hE0);
    poke(5'd16, 8'h07);
    poke(5'd18, 8'hEE);
    run(cyc);
    check("R9 skipped store had no effect", mem[18], 8'hEE);
    check("R9 target store", mem[19], 8'h07);
    check("R9 acc kept", acc_out, 8'h07);
    check("R9 jump program cycles", cyc, 17);

    // R11: wrap from 31 to 0; store at 31 rewrites location 1 as halt
    rst = 1'b1;
    clear_mem();
    poke(5'd0, {3'b100, 5'd16});
    poke(5'd1, {3'b110, 5'd30});
    poke(5'd30, {3'b000, 5'd17});
    poke(5'd31, {3'b101, 5'd1});
    poke(5'd16, 8'hD0);
    poke(5'd17, 8'h10);
    run(cyc);
    check("R11 halted after wrap", halted, 1);
    check("R11 acc reloaded after wrap", acc_out, 8'hD0);
    check("R11 self-written halt", mem[1], 8'hE0);
    check("R11 wrap program cycles", cyc, 27);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule